// File: doc/BRIEF.md
# Serial Control Port Write Receiver

This block is the device side of a four-wire serial control port. A host uses it to write bytes into an on-chip processor. The select, serial clock and serial data input pins are brought into the system clock domain through synchronising flops. The block finds the serial clock edges by oversampling those pins.

A transfer runs while the active-low select is held low. The first byte of every transfer is a header: a 7-bit device address in the upper bits and a direction flag in bit 0, where 0 means write. The transfer is accepted only when that header equals the configured address with the direction flag clear. With the default address, the header is 0x00. Every complete byte after an accepted header goes to the processor as a one-cycle strobe with the byte beside it. The header itself is never passed on.

The serial data output is held low, because read-back is not supported. The active-low interrupt output mirrors the processor's "data pending" flag.

Top module: `spi_wr_rx`

## Requirements
- R1: After reset, `byte_vld_o` is 0 and `sdo_o` is 0.
- R2: Data bytes are delivered only when the first byte of the transfer equals {DEV_ADDR, 1'b0} (0x00 by default). If the first byte differs, no byte of that transfer is delivered.
- R3: A header with the correct address and bit 0 set to 1 (a read request, 0x01 by default) is not accepted, and no byte of that transfer is delivered.
- R4: Serial data is sampled on rising serial clock edges and assembled most significant bit first, so the first bit clocked in lands in `byte_o[7]`.
- R5: A data byte is delivered only after the falling serial clock edge that ends its eighth bit. No byte appears while the eighth clock is still high.
- R6: Any number of data bytes may follow an accepted header within one transfer, and they are delivered in arrival order. The header byte never appears on `byte_o`.
- R7: When select rises in the middle of a byte, the partial byte is discarded. The accepted-header state ends with every transfer, so the first byte of the next transfer is again treated as a header.
- R8: `byte_vld_o` is high for exactly one system clock cycle per delivered byte.
- R9: `sdo_o` stays low at all times.
- R10: `irq_n_o` is the inverse of `pend_i`: it is low while data is pending.
- R11: Serial clock and data activity while select is high has no effect on later transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n_i | input | 1 | Active-low transfer select from the host |
| sclk_i | input | 1 | Serial clock from the host, idles low |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host, held idle low |
| pend_i | input | 1 | Processor has data for the host |
| irq_n_o | output | 1 | Active-low interrupt request to the host |
| byte_vld_o | output | 1 | One-cycle strobe for a received data byte |
| byte_o | output | 8 | Received data byte, valid with the strobe |

## Verification
A bit counter that has drifted out of step shows up at the ports within one byte. Bytes arrive rotated, or a byte is strobed a bit early or late, so the bench compares every delivered value with the bytes it sent. If the header state is wrong, the effect is visible at the end of the first byte of a transfer: bytes are delivered after a bad header, or lost after a good one. State that is carried from one transfer to the next shows up on the first byte after select falls again. The strobe is checked against the falling edge of the eighth clock, to within a few system cycles.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_HDR,
    FR_DATA,
    FR_SKIP
  } frame_st_t;
endpackage

// File: rtl/spi_wr_rst_sync.sv
module spi_wr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign rst_n_s = chain_q[STAGES-1];
endmodule

// File: rtl/spi_wr_sync.sv
module spi_wr_sync #(
  parameter int unsigned      W       = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_wr_shift.sv
module spi_wr_shift
  import spi_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_q
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic              sclk_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  cnt_q, cnt_nx;
  logic [BYTE_W-1:0] sh_q, sh_nx;
  logic              done_nx;

  assign rise = sclk_s & ~sclk_d;
  assign fall = ~sclk_s & sclk_d;

  always_comb begin
    cnt_nx  = cnt_q;
    sh_nx   = sh_q;
    done_nx = 1'b0;
    if (!active) begin
      cnt_nx = '0;
    end else if (rise && (cnt_q < FULL)) begin
      sh_nx  = {sh_q[BYTE_W-2:0], sdi_s};
      cnt_nx = cnt_q + 1'b1;
    end else if (fall && (cnt_q == FULL)) begin
      done_nx = 1'b1;
      cnt_nx  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      byte_done <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      cnt_q     <= cnt_nx;
      sh_q      <= sh_nx;
      byte_done <= done_nx;
    end
  end

  assign byte_q = sh_q;

  // R5: the bit count never passes one full byte
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R5: completion only follows a detected falling clock edge
  assert_done_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> $past(fall));
  // R7: leaving a transfer drops any partial byte
  assert_partial_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (cnt_q == '0 && !byte_done));
endmodule

// File: rtl/spi_wr_frame.sv
module spi_wr_frame
  import spi_wr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_q,
  output logic              vld_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam logic [BYTE_W-1:0] HDR_WR = {DEV_ADDR, 1'b0};

  frame_st_t         st_q, st_nx;
  logic              vld_nx;
  logic [BYTE_W-1:0] data_nx;

  always_comb begin
    st_nx   = st_q;
    vld_nx  = 1'b0;
    data_nx = data_o;
    if (st_q == FR_DATA && byte_done) begin
      vld_nx  = 1'b1;
      data_nx = byte_q;
    end
    if (!active) begin
      st_nx = FR_IDLE;
    end else begin
      case (st_q)
        FR_IDLE: st_nx = FR_HDR;
        FR_HDR:  if (byte_done) st_nx = (byte_q == HDR_WR) ? FR_DATA : FR_SKIP;
        FR_DATA: st_nx = FR_DATA;
        FR_SKIP: st_nx = FR_SKIP;
        default: st_nx = FR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      vld_o  <= 1'b0;
      data_o <= '0;
    end else begin
      st_q   <= st_nx;
      vld_o  <= vld_nx;
      data_o <= data_nx;
    end
  end

  // R2: a strobe only follows a cycle spent in the accepted state
  assert_vld_needs_hdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> ($past(st_q) == FR_DATA));
  // R8: strobe lasts one cycle
  assert_vld_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |=> !vld_o);
  // R7: header acceptance ends with the transfer
  assert_end_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (st_q == FR_IDLE));
endmodule

// File: rtl/spi_wr_rx.sv
module spi_wr_rx
  import spi_wr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = '0,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              pend_i,
  output logic              irq_n_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic       rst_n_s;
  logic [2:0] pins_s;
  logic       active;
  logic       byte_done;
  logic [BYTE_W-1:0] byte_q;

  spi_wr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  spi_wr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n_s),
    .din({sel_n_i, sclk_i, sdi_i}), .dout(pins_s)
  );

  assign active = ~pins_s[2];

  spi_wr_shift u_shift (
    .clk(clk), .rst_n(rst_n_s), .active(active),
    .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .byte_done(byte_done), .byte_q(byte_q)
  );

  spi_wr_frame #(.DEV_ADDR(DEV_ADDR)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .active(active),
    .byte_done(byte_done), .byte_q(byte_q),
    .vld_o(byte_vld_o), .data_o(byte_o)
  );

  assign sdo_o   = 1'b0;
  assign irq_n_o = ~pend_i;
endmodule

// File: tb/spi_wr_rx_bench.sv
module spi_wr_rx_bench;
  localparam int HALF = 8;

  logic clk, rst_n, sel_n, sclk, sdi, pend;
  logic sdo, irq_n, vld;
  logic [7:0] dat;

  int checks = 0, bad = 0, ncap = 0, wide = 0, sdo_bad = 0;
  logic [7:0] cap [64];
  logic prev_vld;
  bit finished = 0;

  spi_wr_rx u_spi_wr_rx (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .pend_i(pend), .irq_n_o(irq_n), .byte_vld_o(vld), .byte_o(dat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    prev_vld <= vld;
    if (rst_n) begin
      if (vld) begin
        cap[ncap[5:0]] <= dat;
        ncap <= ncap + 1;
        if (prev_vld) wide <= wide + 1;
      end
      if (sdo !== 1'b0) sdo_bad <= sdo_bad + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdi = b; wait_clk(HALF);
    sclk = 1'b1; wait_clk(HALF);
    sclk = 1'b0; wait_clk(HALF);
  endtask

  task automatic byte_out(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
  endtask

  task automatic sel_low;  sel_n = 1'b0; wait_clk(HALF); endtask
  task automatic sel_high; wait_clk(HALF); sel_n = 1'b1; wait_clk(2*HALF); endtask

  task automatic t_reset;
    chk(vld === 1'b0, "R1 vld after reset", vld, 0);
    chk(sdo === 1'b0, "R1 sdo after reset", sdo, 0);
  endtask

  task automatic t_irq;
    pend = 1'b1; #1;
    chk(irq_n === 1'b0, "R10 irq with pend", irq_n, 0);
    wait_clk(1); pend = 1'b0; #1;
    chk(irq_n === 1'b1, "R10 irq no pend", irq_n, 1);
  endtask

  task automatic t_single;
    int base = ncap;
    sel_low; byte_out(8'h00); byte_out(8'h01); sel_high;
    chk(ncap - base == 1, "R2 accepted count", ncap - base, 1);
    chk(cap[base[5:0]] == 8'h01, "R4 msb first", cap[base[5:0]], 8'h01);
  endtask

  task automatic t_multi;
    int base = ncap;
    logic [7:0] v [4] = '{8'h12, 8'h34, 8'hF0, 8'h80};
    sel_low; byte_out(8'h00);
    for (int i = 0; i < 4; i++) byte_out(v[i]);
    sel_high;
    chk(ncap - base == 4, "R6 multi count", ncap - base, 4);
    for (int i = 0; i < 4; i++)
      chk(cap[(base + i) % 64] == v[i], "R6 order", cap[(base + i) % 64], v[i]);
  endtask

  task automatic t_badhdr;
    int base = ncap;
    sel_low; byte_out(8'h02); byte_out(8'h55); byte_out(8'h66); sel_high;
    chk(ncap == base, "R2 wrong header", ncap - base, 0);
  endtask

  task automatic t_readbit;
    int base = ncap;
    sel_low; byte_out(8'h01); byte_out(8'h77); sel_high;
    chk(ncap == base, "R3 read header", ncap - base, 0);
  endtask

  task automatic t_eighth_fall;
    int base = ncap;
    sel_low; byte_out(8'h00);
    for (int i = 7; i >= 1; i--) bit_out(i[0]);
    sdi = 1'b1; wait_clk(HALF);
    sclk = 1'b1; wait_clk(3*HALF);
    chk(ncap == base, "R5 none before fall", ncap - base, 0);
    sclk = 1'b0; wait_clk(HALF);
    chk(ncap - base == 1, "R5 after fall", ncap - base, 1);
    chk(cap[base[5:0]] == 8'hAB, "R5 value", cap[base[5:0]], 8'hAB);
    sel_high;
  endtask

  task automatic t_partial;
    int base = ncap;
    sel_low; byte_out(8'h00); bit_out(1); bit_out(0); bit_out(1); bit_out(1); sel_high;
    chk(ncap == base, "R7 partial dropped", ncap - base, 0);
    sel_low; byte_out(8'h00); byte_out(8'h3C); sel_high;
    chk(ncap - base == 1, "R7 fresh after partial", ncap - base, 1);
    chk(cap[base[5:0]] == 8'h3C, "R7 value aligned", cap[base[5:0]], 8'h3C);
    base = ncap;
    sel_low; byte_out(8'h5A); byte_out(8'h11); sel_high;
    chk(ncap == base, "R7 header needed again", ncap - base, 0);
  endtask

  task automatic t_idle_clocks;
    int base = ncap;
    for (int i = 0; i < 5; i++) bit_out(1'b1);
    chk(ncap == base, "R11 idle clocks", ncap - base, 0);
    sel_low; byte_out(8'h00); byte_out(8'h99); sel_high;
    chk(ncap - base == 1 && cap[base[5:0]] == 8'h99, "R11 next transfer",
        cap[base[5:0]], 8'h99);
  endtask

  initial begin
    rst_n = 1'b0; sel_n = 1'b1; sclk = 1'b0; sdi = 1'b0; pend = 1'b0;
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    t_reset;
    t_irq;
    t_single;
    t_multi;
    t_badhdr;
    t_readbit;
    t_eighth_fall;
    t_partial;
    t_idle_clocks;
    chk(wide == 0, "R8 strobe width", wide, 0);
    chk(sdo_bad == 0, "R9 sdo idle", sdo_bad, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule